// File: doc/BRIEF.md
# Auto-Baud Single-Wire Serial Receiver

This block receives asynchronous bytes on a single data pin whose bit rate is not known in advance. After reset, the host sends a fixed calibration byte (81h). The receiver times that byte against the system clock, works out how many clock cycles one bit lasts, and keeps the result as an 8-bit cycle count. Later frames are sampled at mid-bit using that count. Each good byte is presented with a one-cycle valid strobe.

The frame layout is one low start bit, eight data bits with the least significant bit first, and one high stop bit. Any received byte whose upper four bits are all ones is a re-initialize request. The receiver then forgets the learned rate and waits for a new calibration byte.

Reception is gated by a lock byte and an unlock input. When the lock byte is non-zero and unlock is low, line activity is ignored. Driving the pin and interpreting the bytes are left to neighbouring logic.

Top module: `abr_receiver`

## Requirements
- R1: After reset, `learned` is 0, `bit_period` is 0, `overflow` is 0, and no `rx_valid` or `frame_err` pulse occurs before the first frame.
- R2: The first frame after reset or after re-initialization is taken as the calibration byte. It is not delivered on `rx_valid`, and `learned` goes to 1 once it has been timed.
- R3: The learned `bit_period` equals the span from the calibration start-bit falling edge to the second rising edge, divided by 8 and rounded to nearest. The span is measured in clock cycles, and the second rising edge is the one at data bit 7. The value stays constant while `learned` remains 1.
- R4: After learning, each frame is sampled at half a bit period after its falling edge, plus whole bit periods. The data bits are assembled with the least significant bit first. A frame with a high stop bit and an upper nibble other than 1111b appears on `rx_data` with a single-cycle `rx_valid` pulse.
- R5: A received byte whose bits [7:4] are 1111b produces no `rx_valid`. It clears `learned`, `bit_period` and `overflow`, so a new calibration byte is needed before reception resumes.
- R6: Frames that follow each other with no idle time between one stop bit and the next start bit are each received correctly.
- R7: Reception and learning are enabled only when `lock_byte` is 00h or `unlock` is 1. Otherwise falling edges on the pin start neither a frame nor a calibration.
- R8: A low level at the stop-bit sample point produces a single-cycle `frame_err` pulse, and the byte is dropped without `rx_valid`.
- R9: Rounding: a calibration span of 8·N+3 cycles yields N, and a span of 8·N+4 yields N+1.
- R10: If the rounded period exceeds 255, `bit_period` saturates at 255 and `overflow` is set. A period of exactly 255 sets no overflow, and re-initialization clears the flag.
- R11: If the line is high again at the start-bit sample point, the frame is abandoned without `rx_valid` or `frame_err`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_in | input | 1 | Sampled level of the serial data pin, idle high |
| lock_byte | input | 8 | Lock value; 00h enables reception |
| unlock | input | 1 | Forces reception on regardless of `lock_byte` |
| rx_data | output | 8 | Last received byte |
| rx_valid | output | 1 | One-cycle strobe for a new byte on `rx_data` |
| frame_err | output | 1 | One-cycle strobe for a frame with a low stop bit |
| bit_period | output | 8 | Learned bit time in clock cycles |
| learned | output | 1 | Calibration complete |
| overflow | output | 1 | Calibration span too long for 8 bits; period saturated |

## Verification
Every byte value is sent at one rate.

- The sixteen re-initialize codes must each force a relearn. A decoder that checked the wrong nibble, or that delivered those bytes, would show up as missing or extra strobes.
- Calibration spans are placed one cycle either side of a rounding boundary. A truncating divider would then learn a period one cycle short.
- A calibration too long for 8 bits must saturate at 255. A wrapping counter would learn a small period, so the following byte at the 255 rate would be misread.
- Locked-line traffic, a stop bit held low, a short start glitch and back-to-back frames each target one control path. A receiver that failed to gate the start edge, to reject short starts, or to rearm at mid-stop would deliver wrong bytes or count wrong errors.

// File: rtl/abr_pkg.sv
// Shared types for the auto-baud receiver.
// Assumes: nothing beyond IEEE 1800-2017.
package abr_pkg;
    typedef enum logic [1:0] {
        LRN_WAIT  = 2'd0,
        LRN_COUNT = 2'd1,
        LRN_DONE  = 2'd2
    } lrn_state_t;

    typedef enum logic {
        RX_IDLE  = 1'b0,
        RX_SHIFT = 1'b1
    } rx_state_t;

    localparam int BYTE_W   = 8;
    localparam int FRAME_IX = 4;
endpackage

// File: rtl/abr_sync.sv
// Line synchronizer and edge detector.
// Brings the asynchronous pin level into the clock domain through a flop chain.
// Then flags falling and rising edges of the synchronized level.
// Assumes: STAGES >= 2; the line idles high.
module abr_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_in,
    output logic level,
    output logic fall,
    output logic rise
);
    logic [STAGES-1:0] chain;
    logic              prev;

    // Shift the pin through the synchronizer chain and keep the last level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= '1;
            prev  <= 1'b1;
        end else begin
            chain <= {chain[STAGES-2:0], pin_in};
            prev  <= chain[STAGES-1];
        end
    end

    // Decode edges from the synchronized level and its previous value.
    always_comb begin
        level = chain[STAGES-1];
        fall  = prev & ~level;
        rise  = ~prev & level;
    end
endmodule

// File: rtl/abr_measure.sv
// Bit-rate learner.
// Times the calibration byte from its start-bit falling edge to the second
// rising edge, which is eight bit times for 81h.
// Divides that span by eight with rounding and holds the result.
// Saturates and raises overflow when the result does not fit CNT_W bits.
// Assumes: the first enabled frame after reset or relearn is 81h.
module abr_measure
    import abr_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             fall,
    input  logic             rise,
    input  logic             relearn,
    output logic [CNT_W-1:0] period,
    output logic             learned,
    output logic             overflow
);
    localparam int               SPAN_W     = CNT_W + 4;
    localparam logic [SPAN_W-1:0] SPAN_MAX   = '1;
    localparam logic [CNT_W-1:0]  PERIOD_MAX = '1;

    lrn_state_t        state;
    logic [SPAN_W-1:0] span;
    logic              seen_rise;
    logic [SPAN_W:0]   total;
    logic [SPAN_W-2:0] rounded;

    // Span in cycles is span+1; add 4 more to round before dividing by 8.
    always_comb begin
        total   = {1'b0, span} + (SPAN_W+1)'(5);
        rounded = total[SPAN_W:3];
    end

    // Learning sequencer: wait for start, count cycles, latch the rounded period.
    always_ff @(posedge clk) begin
        if (!rst_n || relearn) begin
            state     <= LRN_WAIT;
            span      <= '0;
            seen_rise <= 1'b0;
            period    <= '0;
            learned   <= 1'b0;
            overflow  <= 1'b0;
        end else begin
            case (state)
                LRN_WAIT: begin
                    if (fall && enable) begin
                        state     <= LRN_COUNT;
                        span      <= '0;
                        seen_rise <= 1'b0;
                    end
                end
                LRN_COUNT: begin
                    if (rise && seen_rise) begin
                        state   <= LRN_DONE;
                        learned <= 1'b1;
                        if (rounded > (SPAN_W-1)'(PERIOD_MAX)) begin
                            period   <= PERIOD_MAX;
                            overflow <= 1'b1;
                        end else begin
                            period <= rounded[CNT_W-1:0];
                        end
                    end else begin
                        if (rise) seen_rise <= 1'b1;
                        if (span != SPAN_MAX) span <= span + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    AST_PERIOD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (learned && $past(learned)) |-> $stable(period)); // R3
    AST_OVF_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |-> (period == PERIOD_MAX && learned)); // R10
    AST_UNLEARNED_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !learned |-> (period == '0 && !overflow)); // R5
endmodule

// File: rtl/abr_frame.sv
// Frame sampler.
// On an enabled falling edge, waits half a bit, checks the start bit, then
// samples eight data bits (LSB first) and the stop bit one period apart.
// Delivers the byte, flags a framing error, or requests a relearn when the
// upper nibble is all ones.
// Assumes: period >= 2 once learned.
module abr_frame
    import abr_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              learned,
    input  logic [CNT_W-1:0]  period,
    input  logic              level,
    input  logic              fall,
    output logic [BYTE_W-1:0] rx_data,
    output logic              rx_valid,
    output logic              frame_err,
    output logic              relearn
);
    localparam logic [FRAME_IX-1:0] LAST_DATA = FRAME_IX'(BYTE_W);

    rx_state_t           state;
    logic [CNT_W-1:0]    tmr;
    logic [FRAME_IX-1:0] idx;
    logic [BYTE_W-1:0]   shreg;

    // Frame sequencer: mid-bit timer, bit index, shift register and result pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= RX_IDLE;
            tmr       <= '0;
            idx       <= '0;
            shreg     <= '0;
            rx_data   <= '0;
            rx_valid  <= 1'b0;
            frame_err <= 1'b0;
            relearn   <= 1'b0;
        end else begin
            rx_valid  <= 1'b0;
            frame_err <= 1'b0;
            relearn   <= 1'b0;
            case (state)
                RX_IDLE: begin
                    if (fall && enable && learned) begin
                        state <= RX_SHIFT;
                        tmr   <= period >> 1;
                        idx   <= '0;
                    end
                end
                RX_SHIFT: begin
                    if (!learned) begin
                        state <= RX_IDLE;
                    end else if (tmr != '0) begin
                        tmr <= tmr - 1'b1;
                    end else begin
                        tmr <= period - 1'b1;
                        idx <= idx + 1'b1;
                        if (idx == '0) begin
                            if (level) state <= RX_IDLE;
                        end else if (idx <= LAST_DATA) begin
                            shreg <= {level, shreg[BYTE_W-1:1]};
                        end else begin
                            state <= RX_IDLE;
                            if (!level) begin
                                frame_err <= 1'b1;
                            end else if (&shreg[BYTE_W-1:BYTE_W-4]) begin
                                relearn <= 1'b1;
                            end else begin
                                rx_data  <= shreg;
                                rx_valid <= 1'b1;
                            end
                        end
                    end
                end
                default: state <= RX_IDLE;
            endcase
        end
    end

    AST_LOCKED_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RX_IDLE && !enable) |=> state == RX_IDLE); // R7
    AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid); // R4
    AST_VALID_NEEDS_LEARNED: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> learned); // R2
    AST_VALID_ERR_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(rx_valid && frame_err)); // R8
endmodule

// File: rtl/abr_receiver.sv
// Auto-baud single-wire serial receiver, top level.
// Ties together the synchronizer, the bit-rate learner and the frame sampler.
// Gates every start edge with the lock/unlock condition.
// Assumes: the pin idles high; the clock is chosen so one bit spans 2..255 cycles.
module abr_receiver
    import abr_pkg::*;
#(
    parameter int CNT_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pin_in,
    input  logic [7:0]        lock_byte,
    input  logic              unlock,
    output logic [BYTE_W-1:0] rx_data,
    output logic              rx_valid,
    output logic              frame_err,
    output logic [CNT_W-1:0]  bit_period,
    output logic              learned,
    output logic              overflow
);
    logic level, fall, rise, relearn, enable;

    // Reception is open when the lock byte is clear or unlock is asserted.
    always_comb enable = (lock_byte == 8'h00) || unlock;

    abr_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in),
        .level(level), .fall(fall), .rise(rise)
    );

    abr_measure #(.CNT_W(CNT_W)) u_measure (
        .clk(clk), .rst_n(rst_n), .enable(enable), .fall(fall), .rise(rise),
        .relearn(relearn), .period(bit_period), .learned(learned),
        .overflow(overflow)
    );

    abr_frame #(.CNT_W(CNT_W)) u_frame (
        .clk(clk), .rst_n(rst_n), .enable(enable), .learned(learned),
        .period(bit_period), .level(level), .fall(fall),
        .rx_data(rx_data), .rx_valid(rx_valid), .frame_err(frame_err),
        .relearn(relearn)
    );
endmodule

// File: tb/abr_receiver_test.sv
module abr_receiver_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pin_in = 1'b1;
    logic [7:0] lock_byte = 8'h00;
    logic       unlock = 1'b0;
    logic [7:0] rx_data;
    logic       rx_valid, frame_err, learned, overflow;
    logic [7:0] bit_period;

    int nchk = 0;
    int nfail = 0;
    int nvalid = 0;
    int nerr = 0;
    logic [7:0] log_q [0:511];

    always #10 clk = ~clk;

    abr_receiver uut (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .lock_byte(lock_byte),
        .unlock(unlock), .rx_data(rx_data), .rx_valid(rx_valid),
        .frame_err(frame_err), .bit_period(bit_period), .learned(learned),
        .overflow(overflow)
    );

    // Output monitor, sampling away from the active edge.
    always @(negedge clk) begin
        if (rx_valid) begin
            log_q[nvalid[8:0]] = rx_data;
            nvalid = nvalid + 1;
        end
        if (frame_err) nerr = nerr + 1;
    end

    task automatic check(input string req, input int act, input int exp);
        nchk = nchk + 1;
        if (act != exp) begin
            nfail = nfail + 1;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic drive_bits(input logic [9:0] bits, input int t);
        for (int i = 0; i < 10; i++) begin
            pin_in = bits[i];
            idle(t);
        end
    endtask

    task automatic send_byte(input logic [7:0] b, input int t);
        drive_bits({1'b1, b, 1'b0}, t);
    endtask

    // Calibration byte 81h; the last rising edge is delayed by d cycles.
    task automatic calibrate(input int t, input int d);
        pin_in = 1'b0; idle(t);
        pin_in = 1'b1; idle(t);
        pin_in = 1'b0; idle(6 * t + d);
        pin_in = 1'b1; idle(2 * t);
        idle(4);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        nfail = nfail + 1;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        int v0, e0;
        idle(5);
        rst_n = 1'b1;
        idle(3);
        check("R1 learned", learned, 0);
        check("R1 bit_period", bit_period, 0);
        check("R1 overflow", overflow, 0);
        check("R1 no strobes", nvalid + nerr, 0);

        // First calibration at 8 cycles per bit.
        calibrate(8, 0);
        check("R2 learned", learned, 1);
        check("R2 calibration not delivered", nvalid, 0);
        check("R3 bit_period", bit_period, 8);

        // Sweep every byte value.
        for (int b = 0; b < 256; b++) begin
            v0 = nvalid;
            send_byte(8'(b), 8);
            idle(2);
            if (b[7:4] != 4'hF) begin
                check("R4 strobe count", nvalid, v0 + 1);
                check("R4 data", log_q[v0[8:0]], b);
            end else begin
                idle(4);
                check("R5 no strobe", nvalid, v0);
                check("R5 learned cleared", learned, 0);
                check("R5 period cleared", bit_period, 0);
                calibrate(8, 0);
                check("R5 relearned period", bit_period, 8);
            end
        end
        check("R8 no spurious framing error", nerr, 0);

        // Back-to-back frames.
        v0 = nvalid;
        send_byte(8'h12, 8); send_byte(8'h34, 8); send_byte(8'hE6, 8);
        idle(2);
        check("R6 count", nvalid, v0 + 3);
        check("R6 first", log_q[v0[8:0]], 8'h12);
        check("R6 second", log_q[(v0 + 1) % 512], 8'h34);
        check("R6 third", log_q[(v0 + 2) % 512], 8'hE6);

        // Lock gating of reception.
        lock_byte = 8'h5A;
        v0 = nvalid; e0 = nerr;
        send_byte(8'h33, 8); idle(2);
        check("R7 locked no byte", nvalid, v0);
        check("R7 locked no error", nerr, e0);
        unlock = 1'b1;
        send_byte(8'h44, 8); idle(2);
        check("R7 unlock count", nvalid, v0 + 1);
        check("R7 unlock data", rx_data, 8'h44);

        // Lock gating of learning.
        send_byte(8'hFF, 8); idle(6);
        unlock = 1'b0;
        calibrate(8, 0);
        check("R7 locked no learning", learned, 0);
        lock_byte = 8'h00;
        calibrate(8, 0);
        check("R7 learning after lock clear", bit_period, 8);

        // Framing error.
        v0 = nvalid; e0 = nerr;
        drive_bits({1'b0, 8'h55, 1'b0}, 8);
        pin_in = 1'b1; idle(10);
        check("R8 error pulse", nerr, e0 + 1);
        check("R8 byte dropped", nvalid, v0);
        send_byte(8'h5C, 8); idle(2);
        check("R8 recovery data", rx_data, 8'h5C);

        // Rounding.
        send_byte(8'hF0, 8); idle(6);
        calibrate(20, 3);
        check("R9 round down", bit_period, 20);
        send_byte(8'hFF, 20); idle(6);
        calibrate(20, 4);
        check("R9 round up", bit_period, 21);
        send_byte(8'hA5, 21); idle(2);
        check("R4 data at learned 21", rx_data, 8'hA5);

        // Short start glitch.
        v0 = nvalid; e0 = nerr;
        pin_in = 1'b0; idle(2); pin_in = 1'b1; idle(40);
        check("R11 glitch no byte", nvalid, v0);
        check("R11 glitch no error", nerr, e0);
        send_byte(8'h3C, 21); idle(2);
        check("R11 next frame ok", rx_data, 8'h3C);

        // Overflow.
        send_byte(8'hFF, 21); idle(6);
        calibrate(300, 0);
        check("R10 overflow set", overflow, 1);
        check("R10 saturated", bit_period, 255);
        send_byte(8'hFF, 255); idle(6);
        check("R10 overflow cleared", overflow, 0);
        calibrate(255, 0);
        check("R10 max without overflow", overflow, 0);
        check("R3 period 255", bit_period, 255);
        send_byte(8'h6B, 255); idle(2);
        check("R4 data at 255", rx_data, 8'h6B);

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule